// File: doc/BRIEF.md
# Paged DMA Address Translator

This block translates addresses for two DMA clients through a page-frame table held in on-chip RAM. The CPU loads the table through a write port. Each entry gives the upper part of a physical address. The low twelve bits of a transfer address pass through unchanged, so pages are 4 KB. For every granted client request the block looks up one entry, builds the physical address, and runs a single memory access over a request/acknowledge handshake. It moves the data to memory, or back to the client.

The byte-wide SCSI channel keeps a 16-bit address register. Bits 11:0 give the offset within the page, and bit 15 selects the direction. The channel also keeps a page index that starts at entry 0 and steps forward each time the offset rolls over. The 16-bit Ethernet channel presents a linear byte offset with every request. That offset selects an entry in the upper half of the table. It supports word reads and byte-masked word writes.

Top module: `dpx_page_xlat`

## Requirements
- R1: A CPU table write keeps only bits 11:0 of `map_wdata`. A translated physical address is {entry[11:0], offset[11:0]}.
- R2: Writing the SCSI address register loads it, so `scsi_lo_q` shows the value written. The write also returns the SCSI page index to entry 0.
- R3: With bit 15 of the SCSI register set (device to memory), the block writes `scsi_wdata` to the memory byte at the address. Both lanes carry the byte, and `mem_be` is 01 for an even address and 10 for an odd one. With bit 15 clear, the block reads memory, and the addressed lane (7:0 even, 15:8 odd) appears on `scsi_rdata`.
- R4: Each SCSI byte advances bits 11:0 of the register by one, modulo 4096. Bits 15:12 keep their value.
- R5: When the SCSI offset rolls over to 0, the page index increments. The next byte uses the next table entry.
- R6: An Ethernet access at byte offset X uses table entry 512 + X[20:12] and in-page offset X[11:0]. A read returns the memory word on `eth_rdata`.
- R7: An Ethernet write drives `eth_wdata` as the memory data and `eth_be` as the byte enables. Only the enabled lanes change in memory.
- R8: When both clients request in the same cycle, the SCSI access is served first and the Ethernet access follows.
- R9: `mem_req` stays high with a stable address until `mem_ack`. Each served request produces exactly one single-cycle done pulse on its own channel, in the cycle after `mem_ack`.
- R10: A table write made while a transfer is in flight does not alter that transfer's address. It applies from the next translation.
- R11: After reset, `mem_req`, both done outputs and `scsi_lo_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | CPU table write strobe |
| map_idx | input | 10 | Table entry to write |
| map_wdata | input | 16 | Entry value; upper 4 bits discarded |
| scsi_lo_we | input | 1 | Load the SCSI address register |
| scsi_lo_wdata | input | 16 | New SCSI register value |
| scsi_lo_q | output | 16 | Current SCSI register value |
| scsi_req | input | 1 | One-cycle SCSI byte request |
| scsi_wdata | input | 8 | Byte from the device, for device-to-memory |
| scsi_rdata | output | 8 | Byte read from memory, for memory-to-device |
| scsi_done | output | 1 | SCSI access complete pulse |
| eth_req | input | 1 | One-cycle Ethernet word request |
| eth_we | input | 1 | 1 = write to memory, 0 = read |
| eth_ofs | input | 21 | Linear byte offset |
| eth_wdata | input | 16 | Write word |
| eth_be | input | 2 | Write byte enables |
| eth_rdata | output | 16 | Word read from memory |
| eth_done | output | 1 | Ethernet access complete pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 24 | Physical byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_be | output | 2 | Memory byte enables |
| mem_rdata | input | 16 | Memory read data |
| mem_ack | input | 1 | Memory access complete |

## Verification
Directed runs cover several cases:
- An SCSI run that starts just below a page boundary separates an offset that wraps and moves to the next entry from one that wraps within the same entry.
- A reload after the wrap shows whether the page index returns to zero.
- Both SCSI directions at even and odd addresses check the byte lanes.
- Ethernet writes with each byte-enable pattern check lane masking.
- Simultaneous requests show the service order.
- A table rewrite during a pending access separates the lookup that was already made from the next one.

Random mixes of all these, with random memory latency, check that the address, lane and data stay consistent with an independently kept model.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MEM
  } xl_state_t;

  typedef enum logic {
    CL_SCSI,
    CL_ETH
  } client_t;
endpackage

// File: rtl/dpx_map_ram.sv
module dpx_map_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, read-first, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dpx_scsi_chan.sv
module dpx_scsi_chan #(
  parameter int LO_W  = 16,
  parameter int OFF_W = 12,
  parameter int PG_W  = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lo_we,
  input  logic [LO_W-1:0] lo_wdata,
  input  logic            adv,
  output logic [LO_W-1:0] lo_q,
  output logic [PG_W-1:0] page_q
);
  logic wrap;
  assign wrap = &lo_q[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      page_q <= '0;
    end else if (lo_we) begin
      lo_q   <= lo_wdata;
      page_q <= '0;
    end else if (adv) begin
      lo_q[OFF_W-1:0] <= lo_q[OFF_W-1:0] + 1'b1;
      if (wrap) page_q <= page_q + 1'b1;
    end
  end
endmodule

// File: rtl/dpx_arb.sv
module dpx_arb (
  input  logic clk,
  input  logic rst,
  input  logic req_hi,
  input  logic req_lo,
  input  logic idle,
  output logic gnt_hi,
  output logic gnt_lo
);
  logic pend_hi, pend_lo;

  assign gnt_hi = idle & pend_hi;
  assign gnt_lo = idle & pend_lo & ~pend_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_hi <= 1'b0;
      pend_lo <= 1'b0;
    end else begin
      pend_hi <= (pend_hi & ~gnt_hi) | req_hi;
      pend_lo <= (pend_lo & ~gnt_lo) | req_lo;
    end
  end
endmodule

// File: rtl/dpx_page_xlat.sv
module dpx_page_xlat
  import dpx_pkg::*;
#(
  parameter int MAP_DEPTH = 1024,
  parameter int MAP_W     = 16,
  parameter int PFN_W     = 12,
  parameter int OFF_W     = 12,
  parameter int LO_W      = 16,
  parameter int DATA_W    = 16,
  parameter int BYTE_W    = 8,
  localparam int MAP_AW   = $clog2(MAP_DEPTH),
  localparam int PHYS_W   = PFN_W + OFF_W,
  localparam int ETH_X_W  = OFF_W + MAP_AW - 1,
  localparam int BE_W     = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_we,
  input  logic [MAP_AW-1:0] map_idx,
  input  logic [MAP_W-1:0]  map_wdata,
  input  logic              scsi_lo_we,
  input  logic [LO_W-1:0]   scsi_lo_wdata,
  output logic [LO_W-1:0]   scsi_lo_q,
  input  logic              scsi_req,
  input  logic [BYTE_W-1:0] scsi_wdata,
  output logic [BYTE_W-1:0] scsi_rdata,
  output logic              scsi_done,
  input  logic              eth_req,
  input  logic              eth_we,
  input  logic [ETH_X_W-1:0] eth_ofs,
  input  logic [DATA_W-1:0] eth_wdata,
  input  logic [BE_W-1:0]   eth_be,
  output logic [DATA_W-1:0] eth_rdata,
  output logic              eth_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PHYS_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int LSB_W    = (BE_W > 1) ? $clog2(BE_W) : 1;
  localparam int ETH_BASE = MAP_DEPTH / 2;

  xl_state_t st;
  client_t   cur;
  logic      cur_is_scsi;

  logic [OFF_W-1:0]  off_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [BE_W-1:0]   be_q;

  logic [BYTE_W-1:0]  sbyte_q;
  logic               eth_we_q;
  logic [ETH_X_W-1:0] eth_ofs_q;
  logic [DATA_W-1:0]  eth_wdata_q;
  logic [BE_W-1:0]    eth_be_q;

  logic [MAP_AW-1:0] page_idx;
  logic [MAP_AW-1:0] ram_raddr;
  logic [PFN_W-1:0]  ram_q;
  logic              gnt_s, gnt_e, idle, adv;
  logic [LSB_W-1:0]  lane_q;

  // upper entry bits are discarded on the way into the table
  logic unused_map_hi;
  assign unused_map_hi = ^map_wdata[MAP_W-1:PFN_W];

  assign idle        = (st == ST_IDLE);
  assign cur_is_scsi = (cur == CL_SCSI);
  assign adv         = (st == ST_MEM) && mem_ack && cur_is_scsi;
  assign lane_q      = off_q[LSB_W-1:0];

  assign ram_raddr = gnt_s ? page_idx
                           : MAP_AW'(ETH_BASE) + MAP_AW'(eth_ofs_q[ETH_X_W-1:OFF_W]);

  dpx_arb u_arb (
    .clk    (clk),
    .rst    (rst),
    .req_hi (scsi_req),
    .req_lo (eth_req),
    .idle   (idle),
    .gnt_hi (gnt_s),
    .gnt_lo (gnt_e)
  );

  dpx_scsi_chan #(.LO_W(LO_W), .OFF_W(OFF_W), .PG_W(MAP_AW)) u_scsi (
    .clk      (clk),
    .rst      (rst),
    .lo_we    (scsi_lo_we),
    .lo_wdata (scsi_lo_wdata),
    .adv      (adv),
    .lo_q     (scsi_lo_q),
    .page_q   (page_idx)
  );

  dpx_map_ram #(.DEPTH(MAP_DEPTH), .AW(MAP_AW), .DW(PFN_W)) u_map (
    .clk   (clk),
    .we    (map_we),
    .waddr (map_idx),
    .wdata (map_wdata[PFN_W-1:0]),
    .re    (gnt_s | gnt_e),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  // request parameters are captured with the request pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      sbyte_q     <= '0;
      eth_we_q    <= 1'b0;
      eth_ofs_q   <= '0;
      eth_wdata_q <= '0;
      eth_be_q    <= '0;
    end else begin
      if (scsi_req) sbyte_q <= scsi_wdata;
      if (eth_req) begin
        eth_we_q    <= eth_we;
        eth_ofs_q   <= eth_ofs;
        eth_wdata_q <= eth_wdata;
        eth_be_q    <= eth_be;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur        <= CL_SCSI;
      off_q      <= '0;
      wr_q       <= 1'b0;
      wdat_q     <= '0;
      be_q       <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_be     <= '0;
      scsi_done  <= 1'b0;
      eth_done   <= 1'b0;
      scsi_rdata <= '0;
      eth_rdata  <= '0;
    end else begin
      scsi_done <= 1'b0;
      eth_done  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (gnt_s) begin
            cur    <= CL_SCSI;
            off_q  <= scsi_lo_q[OFF_W-1:0];
            wr_q   <= scsi_lo_q[LO_W-1];
            wdat_q <= {BE_W{sbyte_q}};
            be_q   <= BE_W'(1) << scsi_lo_q[LSB_W-1:0];
            st     <= ST_LOOK;
          end else if (gnt_e) begin
            cur    <= CL_ETH;
            off_q  <= eth_ofs_q[OFF_W-1:0];
            wr_q   <= eth_we_q;
            wdat_q <= eth_wdata_q;
            be_q   <= eth_we_q ? eth_be_q : {BE_W{1'b1}};
            st     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          mem_addr  <= {ram_q, off_q};
          mem_we    <= wr_q;
          mem_wdata <= wdat_q;
          mem_be    <= be_q;
          mem_req   <= 1'b1;
          st        <= ST_MEM;
        end
        ST_MEM: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            st      <= ST_IDLE;
            if (cur_is_scsi) begin
              scsi_done  <= 1'b1;
              scsi_rdata <= mem_rdata[lane_q*BYTE_W +: BYTE_W];
            end else begin
              eth_done  <= 1'b1;
              eth_rdata <= mem_rdata;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpx_page_xlat_chk.sv
module dpx_page_xlat_chk #(
  parameter int PHYS_W = 24,
  parameter int LO_W   = 16,
  parameter int OFF_W  = 12,
  parameter int BE_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [PHYS_W-1:0] mem_addr,
  input logic [BE_W-1:0]   mem_be,
  input logic              scsi_done,
  input logic              eth_done,
  input logic              scsi_lo_we,
  input logic [LO_W-1:0]   scsi_lo_q,
  input logic              cur_scsi
);
  // R9: request held with a stable address until acknowledged
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: a done pulse follows an acknowledge and lasts one cycle
  p_done_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (scsi_done || eth_done) |-> $past(mem_ack));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (scsi_done || eth_done) |=> !(scsi_done || eth_done));

  // R8: only one client completes at a time
  p_single_grant_r8: assert property (@(posedge clk) disable iff (rst)
    !(scsi_done && eth_done));

  // R4: offset steps by one, upper register bits kept
  p_offset_step_r4: assert property (@(posedge clk) disable iff (rst)
    (scsi_done && !$past(scsi_lo_we)) |->
      (scsi_lo_q[OFF_W-1:0] == $past(scsi_lo_q[OFF_W-1:0]) + 1'b1) &&
      (scsi_lo_q[LO_W-1:OFF_W] == $past(scsi_lo_q[LO_W-1:OFF_W])));

  // R3: a SCSI byte access touches exactly one lane
  p_byte_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && cur_scsi) |-> ($countones(mem_be) == 1));
endmodule

bind dpx_page_xlat dpx_page_xlat_chk #(
  .PHYS_W (PFN_W + OFF_W),
  .LO_W   (LO_W),
  .OFF_W  (OFF_W),
  .BE_W   (DATA_W / BYTE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .scsi_done  (scsi_done),
  .eth_done   (eth_done),
  .scsi_lo_we (scsi_lo_we),
  .scsi_lo_q  (scsi_lo_q),
  .cur_scsi   (cur_is_scsi)
);

// File: tb/dpx_page_xlat_tb.sv
module dpx_page_xlat_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_we = 1'b0;
  logic [9:0]  map_idx = '0;
  logic [15:0] map_wdata = '0;
  logic        scsi_lo_we = 1'b0;
  logic [15:0] scsi_lo_wdata = '0;
  logic [15:0] scsi_lo_q;
  logic        scsi_req = 1'b0;
  logic [7:0]  scsi_wdata = '0;
  logic [7:0]  scsi_rdata;
  logic        scsi_done;
  logic        eth_req = 1'b0;
  logic        eth_we = 1'b0;
  logic [20:0] eth_ofs = '0;
  logic [15:0] eth_wdata = '0;
  logic [1:0]  eth_be = '0;
  logic [15:0] eth_rdata;
  logic        eth_done;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [1:0]  mem_be;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2 clk = ~clk;

  dpx_page_xlat u_dut (.*);

  int nchk = 0;
  int nfail = 0;

  // behavioural memory
  logic [15:0] mem_a [int];
  logic [23:0] last_addr;
  logic        last_we;
  logic [1:0]  last_be;
  logic [15:0] last_wdata;
  int          lat = 0;

  function automatic logic [15:0] rd_word(int w);
    if (mem_a.exists(w)) return mem_a[w];
    return 16'(w * 40503) ^ 16'h5A5A;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat == 0) begin
        int w;
        logic [15:0] v;
        w = int'(mem_addr >> 1);
        v = rd_word(w);
        last_addr = mem_addr; last_we = mem_we; last_be = mem_be; last_wdata = mem_wdata;
        if (mem_we) begin
          if (mem_be[0]) v[7:0]  = mem_wdata[7:0];
          if (mem_be[1]) v[15:8] = mem_wdata[15:8];
          mem_a[w] = v;
        end
        mem_rdata = v;
        mem_ack = 1'b1;
        lat = int'($urandom % 3);
      end else begin
        lat = lat - 1;
      end
    end
  end

  // reference model
  logic [11:0] map_m [1024];
  logic [15:0] lo_m = '0;
  logic [9:0]  pg_m = '0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void scsi_model_step();
    if (lo_m[11:0] == 12'hFFF) pg_m = pg_m + 1'b1;
    lo_m[11:0] = lo_m[11:0] + 1'b1;
  endfunction

  task automatic map_write(logic [9:0] idx, logic [15:0] d);
    @(negedge clk);
    map_we = 1'b1; map_idx = idx; map_wdata = d;
    @(negedge clk);
    map_we = 1'b0;
    map_m[idx] = d[11:0];
  endtask

  task automatic set_lo(logic [15:0] v);
    @(negedge clk);
    scsi_lo_we = 1'b1; scsi_lo_wdata = v;
    @(negedge clk);
    scsi_lo_we = 1'b0;
    lo_m = v; pg_m = '0;
    check("R2", "register readback", 32'(scsi_lo_q), 32'(v));
  endtask

  task automatic scsi_xfer(logic [7:0] b, string tag);
    logic [23:0] ea;
    logic [15:0] prev;
    logic        dir;
    ea   = {map_m[pg_m], lo_m[11:0]};
    dir  = lo_m[15];
    prev = rd_word(int'(ea >> 1));
    @(negedge clk);
    scsi_wdata = b; scsi_req = 1'b1;
    @(negedge clk);
    scsi_req = 1'b0;
    while (!scsi_done) @(negedge clk);
    check(tag, "scsi address", 32'(last_addr), 32'(ea));
    check("R3", "scsi direction", 32'(last_we), 32'(dir));
    if (dir) begin
      check("R3", "scsi lane enable", 32'(last_be), ea[0] ? 32'h2 : 32'h1);
      check("R3", "scsi byte stored",
            32'(ea[0] ? rd_word(int'(ea >> 1)) >> 8 : rd_word(int'(ea >> 1)) & 16'hFF), 32'(b));
    end else begin
      check("R3", "scsi byte read", 32'(scsi_rdata), ea[0] ? 32'(prev[15:8]) : 32'(prev[7:0]));
    end
    scsi_model_step();
    check("R4", "register after byte", 32'(scsi_lo_q), 32'(lo_m));
  endtask

  task automatic eth_xfer(logic we, logic [20:0] x, logic [15:0] wd, logic [1:0] be, string tag);
    logic [23:0] ea;
    logic [15:0] prev, expw;
    ea   = {map_m[10'h200 + 10'(x[20:12])], x[11:0]};
    prev = rd_word(int'(ea >> 1));
    expw = prev;
    if (be[0]) expw[7:0]  = wd[7:0];
    if (be[1]) expw[15:8] = wd[15:8];
    @(negedge clk);
    eth_we = we; eth_ofs = x; eth_wdata = wd; eth_be = be; eth_req = 1'b1;
    @(negedge clk);
    eth_req = 1'b0;
    while (!eth_done) @(negedge clk);
    check(tag, "eth address", 32'(last_addr), 32'(ea));
    if (we) begin
      check("R7", "eth byte enables", 32'(last_be), 32'(be));
      check("R7", "eth merged word", 32'(rd_word(int'(ea >> 1))), 32'(expw));
    end else begin
      check("R6", "eth read data", 32'(eth_rdata), 32'(prev));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "mem_req after reset", 32'(mem_req), 0);
    check("R11", "done after reset", 32'({scsi_done, eth_done}), 0);
    check("R11", "scsi register after reset", 32'(scsi_lo_q), 0);

    for (int i = 0; i < 1024; i++) map_write(10'(i), 16'($urandom));

    // R1: upper entry bits discarded
    map_write(10'd0, 16'hF123);
    map_write(10'd1, 16'hA456);
    set_lo(16'h8010);
    scsi_xfer(8'h3C, "R1");
    check("R1", "frame bits", 32'(last_addr[23:12]), 32'h123);

    // R3: both directions, both lanes
    scsi_xfer(8'hC5, "R3");
    set_lo(16'h0020);
    scsi_xfer(8'h00, "R3");
    scsi_xfer(8'h00, "R3");

    // R5: page crossing, R4: upper bits kept across wrap
    set_lo(16'h8FFE);
    scsi_xfer(8'h11, "R5");
    scsi_xfer(8'h22, "R5");
    scsi_xfer(8'h33, "R5");
    check("R5", "next entry used", 32'(last_addr[23:12]), 32'h456);
    set_lo(16'h4FFF);
    scsi_xfer(8'h00, "R5");
    check("R4", "upper nibble kept", 32'(scsi_lo_q), 32'h4000);
    // R2: reload returns to entry 0
    set_lo(16'h0100);
    scsi_xfer(8'h00, "R2");
    check("R2", "page index reset", 32'(last_addr[23:12]), 32'h123);

    // R6/R7: ethernet reads and masked writes
    map_write(10'h200, 16'h0777);
    map_write(10'h3FF, 16'h0888);
    eth_xfer(1'b0, 21'h000_124, 16'h0, 2'b11, "R6");
    eth_xfer(1'b0, 21'h1FF_FFE, 16'h0, 2'b11, "R6");
    check("R6", "top entry", 32'(last_addr), 32'h888FFE);
    eth_xfer(1'b1, 21'h000_200, 16'hBEEF, 2'b01, "R7");
    eth_xfer(1'b1, 21'h000_200, 16'hCAFE, 2'b10, "R7");
    eth_xfer(1'b1, 21'h000_202, 16'h1234, 2'b11, "R7");

    // R8: simultaneous requests
    set_lo(16'h0040);
    @(negedge clk);
    scsi_wdata = 8'h00; scsi_req = 1'b1;
    eth_we = 1'b0; eth_ofs = 21'h000_300; eth_be = 2'b11; eth_req = 1'b1;
    @(negedge clk);
    scsi_req = 1'b0; eth_req = 1'b0;
    while (!scsi_done && !eth_done) @(negedge clk);
    check("R8", "scsi served first", 32'(scsi_done), 1);
    check("R8", "eth waits", 32'(eth_done), 0);
    scsi_model_step();
    while (!eth_done) @(negedge clk);
    check("R8", "eth served after", 32'(last_addr), {8'h0, map_m[10'h200], 12'h300});

    // R10: table rewrite during a pending access
    fork
      eth_xfer(1'b0, 21'h003_456, 16'h0, 2'b11, "R10");
      begin
        @(negedge clk);
        while (!mem_req) @(negedge clk);
        map_write(10'h203, 16'h0ABC);
      end
    join
    eth_xfer(1'b0, 21'h003_456, 16'h0, 2'b11, "R10");
    check("R10", "new entry used", 32'(last_addr[23:12]), 32'hABC);

    // random mix
    for (int n = 0; n < 120; n++) begin
      int k;
      k = int'($urandom % 10);
      if (k < 4) scsi_xfer(8'($urandom), "R3");
      else if (k < 8) eth_xfer(1'($urandom), {9'($urandom), 11'($urandom), 1'b0},
                              16'($urandom), 2'($urandom % 3 + 1), "R6");
      else if (k == 8) set_lo({1'($urandom), 3'($urandom), 12'(12'hFF0 + $urandom % 16)});
      else map_write(10'($urandom), 16'($urandom));
    end

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule